// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Monitor

This block listens to the two lines of an I2C bus without ever driving them and tells the rest of the chip whether a bus transaction is open. Both lines are treated as plain data. They pass through a short synchronizer into the system clock domain. Each synchronized sample is then compared with the sample from the cycle before, which finds edges without clocking anything from the bus.

A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. Each condition raises its own single-cycle pulse. A busy flag is set by START and cleared by STOP or by reset. The raw line levels are also copied to two indicator outputs, for example to light LEDs on a board.

Top module: `i2c_cond_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with both bus lines high, `busy`, `start_pulse` and `stop_pulse` are all 0.
- R2: A START (SDA changing from 1 to 0 while the newly sampled SCL is 1) raises `start_pulse` on the (SYNC_STAGES+1)-th rising clock edge after the line change, and not earlier.
- R3: `busy` reads 1 from the same edge that raises `start_pulse`.
- R4: A STOP (SDA changing from 0 to 1 while the newly sampled SCL is 1) raises `stop_pulse` at the same latency as R2, and `busy` reads 0 from that edge.
- R5: An SDA change while the newly sampled SCL is 0 produces no pulse and leaves `busy` unchanged.
- R6: A START while `busy` is already 1 (repeated START) still produces `start_pulse`, and `busy` stays 1.
- R7: Each pulse lasts exactly one clock cycle, and the two pulses are never high together.
- R8: `scl_led` and `sda_led` follow `scl_in` and `sda_in` with no clock delay.
- R9: Asserting `rst` while `busy` is 1 clears `busy`.
- R10: A change of SCL alone, with SDA steady, produces no pulse and leaves `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy | output | 1 | Transaction open between START and STOP |
| start_pulse | output | 1 | One-cycle START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| scl_led | output | 1 | Copy of SCL level |
| sda_led | output | 1 | Copy of SDA level |

## Verification
A stale previous-sample register or a wrong SCL qualifier shows up at the ports as a missing, extra or misplaced pulse. The pulse timing is fixed, so the fault appears at exactly SYNC_STAGES+1 edges after the line change. A corrupted busy flag shows on the very edge where the pulse should update it, and it stays visible until the next START, STOP or reset. The bench steps through all sixteen line-pair transitions with the flag both set and clear, which covers each of these cases.

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic start_pulse,
  output logic stop_pulse,
  output logic scl_led,
  output logic sda_led
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic          sda_prev;
  logic          scl_now, sda_now;
  logic          saw_start, saw_stop;

  assign scl_led = scl_in;
  assign sda_led = sda_in;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_in};
      sda_sync <= {sda_sync[LAST-1:0], sda_in};
    end
  end

  assign scl_now = scl_sync[LAST];
  assign sda_now = sda_sync[LAST];

  assign saw_start = scl_now &  sda_prev & ~sda_now;
  assign saw_stop  = scl_now & ~sda_prev &  sda_now;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sda_prev    <= 1'b1;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      busy        <= 1'b0;
    end else begin
      sda_prev    <= sda_now;
      start_pulse <= saw_start;
      stop_pulse  <= saw_stop;
      if (saw_start)     busy <= 1'b1;
      else if (saw_stop) busy <= 1'b0;
    end
  end
endmodule

module i2c_cond_monitor_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_in,
  input logic busy,
  input logic start_pulse,
  input logic stop_pulse,
  input logic scl_led,
  input logic sda_led
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) start_pulse |-> busy); // R3
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) stop_pulse |-> !busy); // R4
  AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> start_pulse); // R5
  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> stop_pulse); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) start_pulse |=> !start_pulse); // R7
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) stop_pulse |=> !stop_pulse); // R7
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(start_pulse && stop_pulse)); // R7
  AST_LED_COPY: assert property (@(posedge clk) disable iff (rst) (scl_led == scl_in) && (sda_led == sda_in)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !busy && !start_pulse && !stop_pulse); // R1
endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk u_chk (.*);

// File: tb/sim_i2c_cond_monitor.sv
module sim_i2c_cond_monitor;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic busy, start_pulse, stop_pulse, scl_led, sda_led;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic m_scl = 1'b1, m_sda = 1'b1, m_busy = 1'b0;

  always #4 clk = ~clk;

  i2c_cond_monitor #(.SYNC_STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .busy(busy), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .scl_led(scl_led), .sda_led(sda_led)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {busy,start,stop} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic sc, logic sd, string req);
    logic es, ep;
    es = sc &  m_sda & ~sd;
    ep = sc & ~m_sda &  sd;
    @(negedge clk);
    scl_in = sc; sda_in = sd;
    #1;
    check("R8", {1'b0, scl_led, sda_led}, {1'b0, sc, sd});
    for (int i = 0; i < STAGES; i++) @(posedge clk);
    #1;
    check(req, {busy, start_pulse, stop_pulse}, {m_busy, 2'b00});
    if (es) m_busy = 1'b1;
    else if (ep) m_busy = 1'b0;
    @(posedge clk); #1;
    check(req, {busy, start_pulse, stop_pulse}, {m_busy, es, ep});
    @(posedge clk); #1;
    check("R7", {busy, start_pulse, stop_pulse}, {m_busy, 2'b00});
    m_scl = sc; m_sda = sd;
  endtask

  function automatic string tag(logic ps, logic pd, logic sc, logic sd, logic b);
    if (sc && pd && !sd) return b ? "R6" : "R2";
    if (sc && !pd && sd) return "R4";
    if (pd != sd) return "R5";
    if (ps != sc) return "R10";
    return "R7";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {busy, start_pulse, stop_pulse}, 3'b000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1", {busy, start_pulse, stop_pulse}, 3'b000);

    step(1'b1, 1'b0, "R2");
    check("R3", {busy, 2'b00}, 3'b100);
    step(1'b1, 1'b1, "R4");

    for (int pass = 0; pass < 2; pass++) begin
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          step(1'b0, 1'b1, "R5");
          if (pass == 1 && !m_busy) begin
            step(1'b1, 1'b1, "R10");
            step(1'b1, 1'b0, "R2");
          end
          step(f[1], f[0], tag(m_scl, m_sda, f[1], f[0], m_busy));
          step(t[1], t[0], tag(m_scl, m_sda, t[1], t[0], m_busy));
        end
      end
      step(1'b1, 1'b1, "R10");
      if (m_busy) begin
        step(1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, "R4");
      end
    end

    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R10");
    check("R9", {busy, 2'b00}, 3'b100);
    @(negedge clk); rst = 1'b1;
    #1;
    check("R9", {busy, start_pulse, stop_pulse}, 3'b000);
    @(negedge clk); rst = 1'b0;
    m_busy = 1'b0;
    repeat (STAGES + 2) @(posedge clk);
    #1;
    check("R9", {busy, start_pulse, stop_pulse}, 3'b000);
    step(1'b1, 1'b0, "R10");
    step(1'b1, 1'b1, "R4");

    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule